// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Sequencer

This block is the host-side master for a 1024-word by 16-bit serial EEPROM that uses a three-wire link: select, clock and data in, plus a data-out line read back from the device. A client issues one command at a time on a valid/ready port. A command carries an operation (read, write, write-enable or write-disable), a 10-bit word address, a 16-bit write value and a word count for reads. The sequencer turns the command into a serial frame. It derives the serial clock from the system clock through a programmable half-period divider. It returns read words with a one-cycle strobe and pulses `done` when the transaction is over.

Three jobs are handled by the block, so the client never sees them. It keeps select low for a minimum number of cycles between transactions. On a read it discards the leading zero bit that the device sends before the data, and it streams several words inside one select window. On a write it drops select at the end of the frame, raises it again after the minimum gap, and polls the data-out line until the device reports ready. If ready never comes within a bounded number of cycles, it flags a timeout.

Top module: `mw_eeprom_host`

## Requirements
- R1: Out of reset, `mw_cs`, `mw_sk`, `mw_di`, `rd_valid`, `done` and `err_timeout` are low and `cmd_ready` is high.
- R2: A frame is sent MSB first: start pair `01`, then a 2-bit op code (read `10`, write `01`, enable/disable `00`), then 10 address bits. For enable the address field is `11` followed by eight zeros, and for disable it is all zeros. A write adds the 16 data bits after the address, MSB first. A read or enable/disable frame is exactly 14 serial clock rising edges. A write frame is exactly 30.
- R3: Each serial clock high phase lasts `sk_half` system clock cycles, and a value of 0 counts as 1. `mw_di` changes only while `mw_sk` is low, and `mw_sk` is high only while `mw_cs` is high.
- R4: Every rising edge of `mw_cs` comes after at least `CS_GAP` consecutive cycles with `mw_cs` low. This includes the first one after reset.
- R5: On a read, the data-out bit sampled after the last address bit is discarded. The next 16 samples, each taken at a falling edge of `mw_sk`, form the word MSB first and appear on `rd_data` with a one-cycle `rd_valid` pulse.
- R6: A read returns `cmd_count` words (0 counts as 1) in one `mw_cs` window, for consecutive addresses that wrap from 0x3FF to 0x000.
- R7: After a write frame, `mw_cs` falls before any further serial clock rising edge. It rises again for polling with `mw_sk` held low. `done` comes only once `mw_do` reads 1.
- R8: If `mw_do` stays 0 for `POLL_LIMIT` cycles of polling, the block drops `mw_cs` and pulses `err_timeout` together with `done`.
- R9: `cmd_ready` is high only while idle. A command is taken on `cmd_valid && cmd_ready`. `done` is a single-cycle pulse at the end of every command.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sk_half | input | DIV_W | Serial clock half-period in system cycles (0 means 1); held stable during a command |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | Operation: 0 read, 1 write, 2 write-enable, 3 write-disable |
| cmd_addr | input | 10 | Word address |
| cmd_wdata | input | 16 | Write value |
| cmd_count | input | CNT_W | Number of words to read (0 means 1) |
| rd_data | output | 16 | Last word read |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | One-cycle pulse at the end of a command |
| err_timeout | output | 1 | One-cycle pulse with `done` when busy polling timed out |
| mw_cs | output | 1 | Device select |
| mw_sk | output | 1 | Serial clock |
| mw_di | output | 1 | Serial data to the device |
| mw_do | input | 1 | Serial data from the device |

## Verification
A wrong bit counter or shift register shows up at the device pins within one frame: the device model records a frame of the wrong length or with misplaced fields as soon as select falls. A slip in read alignment, such as keeping the dummy bit or missing the wrap, corrupts the very first returned word, or the first word after 0x3FF. Such a slip is caught against the bench's reference copy of memory. Divider, gap or polling faults appear as a wrong high-phase length, a short select-low run, or a `done` that arrives before the device's busy time has passed, and each is measured cycle by cycle at the pins.

// File: rtl/mw_pkg.sv
// Package: shared constants, command and state types, and the frame builder
// for the three-wire EEPROM host sequencer.
package mw_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 16;
    localparam int HDR_W   = 4 + ADDR_W;          // start pair + op code + address
    localparam int FRAME_W = HDR_W + DATA_W;      // longest frame (write)

    typedef enum logic [1:0] {
        MW_READ  = 2'd0,
        MW_WRITE = 2'd1,
        MW_WREN  = 2'd2,
        MW_WRDIS = 2'd3
    } mw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SHIFT,
        ST_RDATA,
        ST_WGAP,
        ST_POLL
    } mw_state_e;

    // Build a left-aligned serial frame; the low DATA_W bits are sent only for writes.
    function automatic logic [FRAME_W-1:0] mw_frame(input mw_op_e op,
                                                    input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] wd);
        logic [FRAME_W-1:0] f;
        case (op)
            MW_READ:  f = {2'b01, 2'b10, addr, {DATA_W{1'b0}}};
            MW_WRITE: f = {2'b01, 2'b01, addr, wd};
            MW_WREN:  f = {2'b01, 2'b00, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
            default:  f = {2'b01, 2'b00, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/mw_sat_counter.sv
// Saturating up-counter: counts enabled cycles since the last clear and
// reports when LIMIT has been reached. Assumes LIMIT >= 1.
module mw_sat_counter #(
    parameter int LIMIT = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic reached
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign reached = (cnt_q == CW'(LIMIT));

    // Count up while enabled, hold at the limit, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear)            cnt_q <= '0;
        else if (inc && !reached)  cnt_q <= cnt_q + 1'b1;
    end

    p_hold_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !clear) |=> reached);

endmodule

// File: rtl/mw_sk_gen.sv
// Serial clock timebase: while enabled, emits a one-cycle tick every
// `half` system cycles (0 treated as 1). Each tick is one SK half-period.
// Assumes `half` is held stable while enabled.
module mw_sk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    assign last = (half == '0) ? '0 : half - 1'b1;
    assign tick = en && (cnt_q >= last);

    // Cycle counter inside the current half-period; idle at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= last));

endmodule

// File: rtl/mw_eeprom_host.sv
// Host sequencer for a 1024x16 three-wire serial EEPROM. Takes one command at
// a time, serialises the frame on mw_cs/mw_sk/mw_di, collects read data from
// mw_do (dropping the leading dummy bit), and polls busy/ready after writes.
// Assumes sk_half is stable for the duration of a command and that the device
// samples mw_di and updates mw_do on rising edges of mw_sk.
module mw_eeprom_host
    import mw_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int CNT_W      = 11,
    parameter int CS_GAP     = 25,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  sk_half,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              err_timeout,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_di,
    input  logic              mw_do
);
    localparam int BC_W = $clog2(FRAME_W + 1);
    localparam int RB_W = $clog2(DATA_W + 1);

    mw_state_e          state_q;
    mw_op_e             op_q;
    logic [FRAME_W-1:0] frame_q;
    logic [BC_W-1:0]    bit_cnt_q;
    logic [RB_W-1:0]    rbit_q;
    logic [CNT_W-1:0]   words_q;
    logic [DATA_W-2:0]  rshift_q;
    logic [DATA_W-1:0]  rd_next;
    logic [DATA_W-1:0]  rd_data_q;
    logic               cs_q, sk_q, di_q;
    logic               rd_valid_q, done_q, err_q;
    logic               tick, gap_ok, timed_out, sk_en;

    assign cmd_ready   = (state_q == ST_IDLE);
    assign rd_next     = {rshift_q, mw_do};
    assign sk_en       = (state_q == ST_SHIFT) || (state_q == ST_RDATA) || (state_q == ST_POLL);
    assign mw_cs       = cs_q;
    assign mw_sk       = sk_q;
    assign mw_di       = di_q;
    assign rd_data     = rd_data_q;
    assign rd_valid    = rd_valid_q;
    assign done        = done_q;
    assign err_timeout = err_q;

    mw_sk_gen #(.DIV_W(DIV_W)) i_sk_gen (
        .clk(clk), .rst_n(rst_n), .en(sk_en), .half(sk_half), .tick(tick)
    );

    mw_sat_counter #(.LIMIT(CS_GAP)) i_gap_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cs_q), .inc(1'b1), .reached(gap_ok)
    );

    mw_sat_counter #(.LIMIT(POLL_LIMIT)) i_poll_cnt (
        .clk(clk), .rst_n(rst_n), .clear(state_q != ST_POLL), .inc(1'b1),
        .reached(timed_out)
    );

    // Transaction sequencer: frame shift, read streaming and busy polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= MW_READ;
            frame_q    <= '0;
            bit_cnt_q  <= '0;
            rbit_q     <= '0;
            words_q    <= '0;
            rshift_q   <= '0;
            rd_data_q  <= '0;
            cs_q       <= 1'b0;
            sk_q       <= 1'b0;
            di_q       <= 1'b0;
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q      <= mw_op_e'(cmd_op);
                        frame_q   <= mw_frame(mw_op_e'(cmd_op), cmd_addr, cmd_wdata);
                        bit_cnt_q <= (mw_op_e'(cmd_op) == MW_WRITE) ? BC_W'(FRAME_W)
                                                                    : BC_W'(HDR_W);
                        words_q   <= (cmd_count == '0) ? CNT_W'(1) : cmd_count;
                        state_q   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_ok) begin
                        cs_q    <= 1'b1;
                        di_q    <= frame_q[FRAME_W-1];
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sk_q) begin
                            sk_q      <= 1'b1;
                            bit_cnt_q <= bit_cnt_q - 1'b1;
                        end else begin
                            sk_q <= 1'b0;
                            if (bit_cnt_q == '0) begin
                                di_q <= 1'b0;
                                if (op_q == MW_READ) begin
                                    // This falling edge samples the dummy bit; it is dropped.
                                    rbit_q  <= RB_W'(DATA_W);
                                    state_q <= ST_RDATA;
                                end else if (op_q == MW_WRITE) begin
                                    cs_q    <= 1'b0;
                                    state_q <= ST_WGAP;
                                end else begin
                                    cs_q    <= 1'b0;
                                    done_q  <= 1'b1;
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                frame_q <= frame_q << 1;
                                di_q    <= frame_q[FRAME_W-2];
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (tick) begin
                        if (!sk_q) begin
                            sk_q <= 1'b1;
                        end else begin
                            sk_q     <= 1'b0;
                            rshift_q <= rd_next[DATA_W-2:0];
                            if (rbit_q == RB_W'(1)) begin
                                rd_data_q  <= rd_next;
                                rd_valid_q <= 1'b1;
                                rbit_q     <= RB_W'(DATA_W);
                                if (words_q == CNT_W'(1)) begin
                                    cs_q    <= 1'b0;
                                    done_q  <= 1'b1;
                                    state_q <= ST_IDLE;
                                end else begin
                                    words_q <= words_q - 1'b1;
                                end
                            end else begin
                                rbit_q <= rbit_q - 1'b1;
                            end
                        end
                    end
                end
                ST_WGAP: begin
                    if (gap_ok) begin
                        cs_q    <= 1'b1;
                        state_q <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (timed_out) begin
                        cs_q    <= 1'b0;
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (tick && mw_do) begin
                        cs_q    <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Idle means the link is parked.
    p_idle_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mw_cs && !mw_sk));
    // Select only rises once the gap counter has seen enough low cycles.
    p_cs_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_q) |-> $past(gap_ok));
    // DI is held through each SK high phase.
    p_di_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_q && $past(sk_q)) |-> $stable(di_q));
    // SK never toggles outside a select window.
    p_sk_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sk_q |-> cs_q);
    // Polling keeps SK low.
    p_poll_sk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> !sk_q);
    // Timeout error ends the command with select released.
    p_timeout_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (done_q && !cs_q));
    // Read strobe and done are single-cycle pulses.
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_q |=> !rd_valid_q);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: tb/test_mw_eeprom_host.sv
// Bench for mw_eeprom_host: a behavioural 1024x16 device model on the pins,
// pin-level timing monitors, directed corner cases and seeded random traffic.
module test_mw_eeprom_host;
    import mw_pkg::*;

    localparam int DIV_W      = 8;
    localparam int CNT_W      = 11;
    localparam int CS_GAP     = 25;
    localparam int POLL_LIMIT = 3000;
    localparam int BUSY_CYC   = 400;
    localparam int WD_LIMIT   = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  sk_half = 8'd2;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [1:0]        cmd_op = 2'd0;
    logic [9:0]        cmd_addr = '0;
    logic [15:0]       cmd_wdata = '0;
    logic [CNT_W-1:0]  cmd_count = '0;
    logic [15:0]       rd_data;
    logic              rd_valid, done, err_timeout;
    logic              mw_cs, mw_sk, mw_di;
    logic              mw_do;

    always #5 clk = ~clk;

    mw_eeprom_host #(.DIV_W(DIV_W), .CNT_W(CNT_W), .CS_GAP(CS_GAP),
                     .POLL_LIMIT(POLL_LIMIT)) i_mw_eeprom_host (
        .clk(clk), .rst_n(rst_n), .sk_half(sk_half), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_count(cmd_count), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done), .err_timeout(err_timeout),
        .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- device model ----------------
    logic [15:0] dev_mem [1024];
    logic [15:0] ref_mem [1024];
    bit          dev_we = 0, dev_busy = 0, dev_stuck = 0, reading = 0;
    int          busy_cnt = 0, rx_cnt = 0, rbit = 15, last_n = 0;
    logic [29:0] rx = '0, last_rx = '0;
    logic [9:0]  pend_addr = '0, raddr = '0;
    logic [15:0] pend_data = '0;
    logic        do_q = 1'b0, cs_p = 1'b0, sk_p = 1'b0;
    assign mw_do = do_q;

    always @(negedge clk) begin
        if (dev_busy && !dev_stuck) begin
            if (busy_cnt <= 1) begin dev_busy = 0; dev_mem[pend_addr] = pend_data; end
            else busy_cnt--;
        end
        if (!mw_cs) begin
            if (cs_p && rx_cnt > 0) begin
                last_rx = rx; last_n = rx_cnt;
                if (rx_cnt == 30 && rx[29:26] == 4'b0101 && dev_we) begin
                    dev_busy = 1; busy_cnt = BUSY_CYC;
                    pend_addr = rx[25:16]; pend_data = rx[15:0];
                end
            end
            rx_cnt = 0; reading = 0; do_q = 1'b0;
        end else if (mw_sk && !sk_p) begin
            if (reading) begin
                do_q = dev_mem[raddr][rbit];
                if (rbit == 0) begin rbit = 15; raddr = raddr + 10'd1; end
                else rbit--;
            end else begin
                rx = {rx[28:0], mw_di}; rx_cnt++;
                if (rx_cnt == 14) begin
                    if (rx[13:10] == 4'b0110) begin
                        reading = 1; raddr = rx[9:0]; rbit = 15; do_q = 1'b0;
                    end else if (rx[13:10] == 4'b0100) begin
                        if (rx[9:8] == 2'b11) dev_we = 1;
                        else if (rx[9:8] == 2'b00) dev_we = 0;
                    end
                end
            end
        end else if (rx_cnt == 0 && !reading) begin
            do_q = !dev_busy;
        end
        cs_p = mw_cs; sk_p = mw_sk;
    end

    // ---------------- pin monitors ----------------
    int  hi_run = 0, lo_run = 0, sk_bad = 0, di_bad = 0, gap_bad = 0;
    int  rd_n = 0;
    logic [15:0] rd_buf [256];
    logic m_sk = 0, m_di = 0, m_cs = 0;
    int  eff_half;
    always_comb eff_half = (sk_half == 0) ? 1 : int'(sk_half);

    always @(negedge clk) begin
        if (rst_n) begin
            if (mw_sk) hi_run++;
            if (m_sk && !mw_sk) begin
                if (hi_run != eff_half) sk_bad++;
                hi_run = 0;
            end
            if (mw_sk && m_sk && (mw_di != m_di)) di_bad++;
            if (mw_sk && !mw_cs) sk_bad++;
            if (!mw_cs) lo_run++;
            if (mw_cs && !m_cs) begin
                if (lo_run < CS_GAP) gap_bad++;
                lo_run = 0;
            end
            if (rd_valid) begin rd_buf[rd_n % 256] = rd_data; rd_n++; end
        end
        m_sk = mw_sk; m_di = mw_di; m_cs = mw_cs;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [29:0] exp_frame(input int op, input logic [9:0] a,
                                              input logic [15:0] d);
        case (op)
            0:       return {16'h0, 4'b0110, a};
            1:       return {4'b0101, a, d};
            2:       return {16'h0, 4'b0100, 10'b1100000000};
            default: return {16'h0, 4'b0100, 10'b0000000000};
        endcase
    endfunction

    bit we_ref = 0;
    int last_cycles = 0;
    bit last_err = 0;

    task automatic run_cmd(input int op, input logic [9:0] a, input logic [15:0] d,
                           input int cnt);
        @(negedge clk);
        while (!cmd_ready && cyc < WD_LIMIT) @(negedge clk);
        cmd_op = op[1:0]; cmd_addr = a; cmd_wdata = d; cmd_count = CNT_W'(cnt);
        cmd_valid = 1'b1;
        last_cycles = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R9 ready drops after accept", 32'(cmd_ready), 0);
        while (!done && cyc < WD_LIMIT) @(negedge clk);
        last_err = err_timeout;
        last_cycles = cyc - last_cycles;
        @(negedge clk);
        check(!done, "R9 done is one cycle", 32'(done), 0);
        check(!mw_cs, "R9 select released at end", 32'(mw_cs), 0);
    endtask

    task automatic do_ew(input bit en);
        run_cmd(en ? 2 : 3, 10'h2A5, 16'hFFFF, 0);
        we_ref = en;
        check(last_n == 14, "R2 enable/disable frame length", 32'(last_n), 14);
        check(last_rx[13:0] == exp_frame(en ? 2 : 3, 0, 0)[13:0], "R2 enable/disable frame",
              32'(last_rx[13:0]), 32'(exp_frame(en ? 2 : 3, 0, 0)[13:0]));
    endtask

    task automatic do_write(input logic [9:0] a, input logic [15:0] d);
        run_cmd(1, a, d, 0);
        check(last_n == 30, "R7 write frame has 30 rising edges", 32'(last_n), 30);
        check(last_rx == exp_frame(1, a, d), "R2 write frame bits",
              32'(last_rx), 32'(exp_frame(1, a, d)));
        check(!last_err, "R7 write completes without timeout", 32'(last_err), 0);
        if (we_ref) begin
            check(last_cycles > BUSY_CYC, "R7 done waits for ready",
                  32'(last_cycles), BUSY_CYC);
            ref_mem[a] = d;
        end
    endtask

    task automatic do_read(input logic [9:0] a, input int cnt);
        int base, nw;
        base = rd_n;
        nw = (cnt == 0) ? 1 : cnt;
        run_cmd(0, a, 16'h0, cnt);
        check(last_rx[13:0] == exp_frame(0, a, 0)[13:0], "R2 read frame bits",
              32'(last_rx[13:0]), 32'(exp_frame(0, a, 0)[13:0]));
        check(rd_n - base == nw, "R6 word count in one window", 32'(rd_n - base), 32'(nw));
        for (int k = 0; k < nw && k < rd_n - base; k++) begin
            logic [9:0] ea;
            ea = a + 10'(k);
            check(rd_buf[(base + k) % 256] == ref_mem[ea], "R5 R6 read word",
                  32'(rd_buf[(base + k) % 256]), 32'(ref_mem[ea]));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait (cyc >= WD_LIMIT);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 1024; i++) begin
            dev_mem[i] = 16'(i * 37) ^ 16'h5A5A;
            ref_mem[i] = 16'(i * 37) ^ 16'h5A5A;
        end
        repeat (4) @(negedge clk);
        check(!mw_cs && !mw_sk && !mw_di, "R1 pins low in reset", {mw_cs, mw_sk, mw_di}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready, "R1 ready after reset", 32'(cmd_ready), 1);
        check(!done && !rd_valid && !err_timeout, "R1 strobes low after reset",
              {done, rd_valid, err_timeout}, 0);

        // Directed: protection, wrap, dummy skip, divider corner.
        sk_half = 8'd2;
        do_ew(1'b1);
        do_write(10'h3FF, 16'hA5C3);
        do_write(10'h000, 16'h1234);
        do_read(10'h3FF, 2);                 // R6 wrap 0x3FF -> 0x000
        do_ew(1'b0);
        do_write(10'h005, 16'hFFFF);         // ignored by device while disabled
        do_read(10'h005, 0);                 // R6 count 0 means one word
        sk_half = 8'd0;                      // R3 zero divider acts as one
        do_read(10'h3FE, 3);
        sk_half = 8'd1;
        do_read(10'h100, 1);

        // Seeded random traffic.
        void'($urandom(32'd20240917));
        for (int n = 0; n < 30; n++) begin
            int sel;
            logic [9:0] a;
            sk_half = DIV_W'(1 + ($urandom % 4));
            sel = $urandom % 10;
            a = 10'($urandom);
            if (sel < 5)      do_read(a, 1 + ($urandom % 4));
            else if (sel < 8) begin
                if (!we_ref && ($urandom % 4) != 0) do_ew(1'b1);
                do_write(a, 16'($urandom));
            end else if (sel == 8) do_ew(1'b1);
            else                   do_ew(1'b0);
        end

        // Timeout: device never reports ready (R8).
        sk_half = 8'd2;
        do_ew(1'b1);
        dev_stuck = 1;
        run_cmd(1, 10'h0AA, 16'hBEEF, 0);
        check(last_err, "R8 timeout flagged", 32'(last_err), 1);
        check(last_cycles >= POLL_LIMIT, "R8 timeout not early", 32'(last_cycles), POLL_LIMIT);
        dev_stuck = 0;
        ref_mem[10'h0AA] = 16'hBEEF;
        repeat (BUSY_CYC + 50) @(negedge clk);
        do_read(10'h0A9, 3);

        check(sk_bad == 0, "R3 SK high phase and select", 32'(sk_bad), 0);
        check(di_bad == 0, "R3 DI stable while SK high", 32'(di_bad), 0);
        check(gap_bad == 0, "R4 select low gap", 32'(gap_bad), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule